// File: doc/BRIEF.md
# Three-Address Instruction Sequencer

This block is the control core of a small memory-to-memory processor. It steps through a program held in an instruction memory, one word at a time and strictly in order. Every word names two source words and one destination word of a data memory, plus an operation code. For each operation the sequencer reads both sources, passes them and the code to an external execution unit, and waits for that unit to report completion. It then stores the result at the destination. There is no register file: every operand comes from the data memory and every result goes back to it.

A flag bit in each instruction selects one of two transfer modes. In single mode the instruction moves one operand pair. In block mode the same operation is repeated over a run of consecutive entries. The three addresses advance together by one per entry and wrap around the data memory. A dedicated halt code, or running past the last instruction slot, ends the program and raises a finished flag. A start pulse launches the program from slot 0.

Both memories have registered reads: data appears one cycle after its address. The execution unit latches its operands on the start pulse and answers with a single-cycle done pulse that carries the result, no earlier than the cycle after the start.

The controller has eight states:
- IDLE: after reset.
- FETCH: the program counter drives the instruction address.
- LOAD: the instruction word arrives and is latched.
- READ: the operand addresses are driven; a halt code leads to DONE instead.
- ISSUE: the start pulse goes out.
- WAIT: the controller waits for the done pulse.
- WRITE: the result is written.
- DONE: the program has ended.

The transitions are:
- IDLE or DONE to FETCH on start.
- FETCH to LOAD, and LOAD to READ.
- READ to ISSUE, or READ to DONE on halt.
- ISSUE to WAIT.
- WAIT to WRITE on done.
- WRITE to READ for the next block entry.
- WRITE to FETCH for the next instruction.
- WRITE to DONE after the last slot.

Top module: `tac_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, finished_o, ex_start_o and dmem_we_o are all low until start_i is pulsed.
- R2: The instruction word is laid out, from the least significant end, as: destination C in bits [AW-1:0], source B in [2AW-1:AW], source A in [3AW-1:2AW], the operation in [3AW+OPW-1:3AW], and the block flag as the top bit. The execution unit receives the operation field on ex_op_o and the words at A and B on ex_a_o and ex_b_o. Its result is written to word C.
- R3: Instructions are fetched from slot 0 upward and completed strictly in program order, so a result that depends on every earlier instruction comes out as a sequential evaluation predicts.
- R4: An instruction with the block flag clear produces exactly one ex_start_o pulse and one write.
- R5: An instruction with the block flag set produces BLK_LEN (default 18) operations. Entry k uses addresses A+k, B+k and C+k modulo 2^AW.
- R6: No ex_start_o pulse is issued while a previous start has not yet been answered by ex_done_i.
- R7: dmem_we_o is asserted only in the cycle after an ex_done_i pulse. A read issued after a write to the same word returns the written value, including between entries of one block.
- R8: The operation code with all bits set (7 by default) is a halt. It starts no operation, writes nothing, stops fetching and raises finished_o. While finished_o is high, no start or write occurs.
- R9: After the instruction in the last slot (2^PCW-1) completes, the sequencer raises finished_o without fetching further.
- R10: A start_i pulse while busy_o is high is ignored. A start_i pulse while finished_o is high clears finished_o, raises busy_o and reruns the program from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the program from slot 0 |
| imem_addr_o | output | PCW | Instruction memory read address |
| imem_rdata_i | input | 1+OPW+3*AW | Instruction word, valid one cycle after its address |
| dmem_raddr_a_o | output | AW | Data memory read address, source A |
| dmem_raddr_b_o | output | AW | Data memory read address, source B |
| dmem_rdata_a_i | input | DW | Source A data, one cycle after its address |
| dmem_rdata_b_i | input | DW | Source B data, one cycle after its address |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_waddr_o | output | AW | Data memory write address |
| dmem_wdata_o | output | DW | Data memory write data |
| ex_start_o | output | 1 | One-cycle start pulse to the execution unit |
| ex_op_o | output | OPW | Operation code to the execution unit |
| ex_a_o | output | DW | First operand |
| ex_b_o | output | DW | Second operand |
| ex_done_i | input | 1 | One-cycle completion pulse from the execution unit |
| ex_result_i | input | DW | Result, valid with ex_done_i |
| busy_o | output | 1 | A program is running |
| finished_o | output | 1 | The program has ended by halt or by reaching the last slot |

## Verification
Two functions can meet in adjacent cycles: the write-back of one block entry, and the operand read of the next entry, which may target the word just written. The bench provokes this with a block instruction whose destination run starts one word above its first source run. This turns the block into a running sum in which every entry reads the previous entry's result. With a zero-latency execution unit the write and the dependent read sit back to back. The final memory image is judged word by word against a sequential model; any stale read breaks the chain of sums. The same image checks also cover a start pulse injected mid-run, and the halt and end-of-program cases.

// File: rtl/tac_pkg.sv
package tac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_READ,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/tac_field_split.sv
module tac_field_split #(
    parameter int AW  = 6,
    parameter int OPW = 3
) (
    input  logic [OPW+3*AW:0] word_i,
    output logic              blk_o,
    output logic [OPW-1:0]    op_o,
    output logic [AW-1:0]     a_o,
    output logic [AW-1:0]     b_o,
    output logic [AW-1:0]     c_o,
    output logic              halt_o
);
    // R2: field positions, destination at the least significant end
    assign c_o    = word_i[AW-1:0];
    assign b_o    = word_i[2*AW-1:AW];
    assign a_o    = word_i[3*AW-1:2*AW];
    assign op_o   = word_i[3*AW+OPW-1:3*AW];
    assign blk_o  = word_i[OPW+3*AW];
    assign halt_o = &op_o;
endmodule

// File: rtl/tac_addr_walk.sv
module tac_addr_walk #(
    parameter int AW      = 6,
    parameter int BLK_LEN = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          advance_i,
    input  logic          blk_i,
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    input  logic [AW-1:0] c_i,
    output logic [AW-1:0] raddr_a_o,
    output logic [AW-1:0] raddr_b_o,
    output logic [AW-1:0] waddr_o,
    output logic          last_o
);
    localparam int IDXW = $clog2(BLK_LEN + 1);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(BLK_LEN - 1);

    logic [IDXW-1:0] idx_q;
    logic [AW-1:0]   offs;

    assign offs      = AW'(idx_q);
    assign raddr_a_o = a_i + offs;
    assign raddr_b_o = b_i + offs;
    assign waddr_o   = c_i + offs;
    assign last_o    = !blk_i || (idx_q == IDX_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (advance_i && !last_o) begin
            idx_q <= idx_q + IDXW'(1);
        end
    end

    // R5: the next entry of a block reads one word further on
    p_block_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !last_o) |=> (raddr_a_o == $past(raddr_a_o) + AW'(1)))
        else $error("p_block_step_r5");
endmodule

// File: rtl/tac_ctrl_fsm.sv
module tac_ctrl_fsm
    import tac_pkg::*;
#(
    parameter int AW  = 6,
    parameter int OPW = 3,
    parameter int DW  = 16,
    parameter int PCW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [OPW+3*AW:0]   imem_rdata_i,
    input  logic                halt_i,
    input  logic                last_i,
    input  logic                ex_done_i,
    input  logic [DW-1:0]       ex_result_i,
    output logic [PCW-1:0]      pc_o,
    output logic [OPW+3*AW:0]   instr_o,
    output logic                clear_o,
    output logic                advance_o,
    output logic                ex_start_o,
    output logic                dmem_we_o,
    output logic [DW-1:0]       dmem_wdata_o,
    output logic                busy_o,
    output logic                finished_o
);
    localparam logic [PCW-1:0] PC_LAST = {PCW{1'b1}};

    seq_state_e           state_q, state_d;
    logic [PCW-1:0]       pc_q;
    logic [OPW+3*AW:0]    instr_q;
    logic [DW-1:0]        res_q;
    logic                 idle_like;

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_READ;
            ST_READ:  state_d = halt_i ? ST_DONE : ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (ex_done_i) state_d = ST_WRITE;
            ST_WRITE: begin
                if (!last_i)              state_d = ST_READ;
                else if (pc_q == PC_LAST) state_d = ST_DONE;
                else                      state_d = ST_FETCH;
            end
            ST_DONE:  if (start_i) state_d = ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            instr_q <= '0;
            res_q   <= '0;
        end else begin
            if (idle_like && start_i)
                pc_q <= '0;
            else if (state_q == ST_WRITE && last_i && pc_q != PC_LAST)
                pc_q <= pc_q + PCW'(1);
            if (state_q == ST_LOAD)
                instr_q <= imem_rdata_i;
            if (state_q == ST_WAIT && ex_done_i)
                res_q <= ex_result_i;
        end
    end

    // outputs
    always_comb begin
        pc_o         = pc_q;
        instr_o      = instr_q;
        dmem_wdata_o = res_q;
        clear_o      = (state_q == ST_LOAD);
        advance_o    = (state_q == ST_WRITE);
        ex_start_o   = (state_q == ST_ISSUE);
        dmem_we_o    = (state_q == ST_WRITE);
        busy_o       = !idle_like;
        finished_o   = (state_q == ST_DONE);
    end

    // checker state: one start is awaiting its done
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (ex_start_o) pend_q <= 1'b1;
        else if (ex_done_i)  pend_q <= 1'b0;
    end

    // R1: quiet outputs during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!busy_o && !finished_o && !ex_start_o && !dmem_we_o)
                else $error("p_reset_quiet_r1");
        end
    end

    // R6: at most one operation outstanding
    p_single_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_start_o |-> !pend_q)
        else $error("p_single_issue_r6");

    // R7: a write follows a done pulse
    p_write_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we_o |-> $past(ex_done_i))
        else $error("p_write_after_done_r7");

    // R8: nothing moves once finished
    p_finished_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |-> (!ex_start_o && !dmem_we_o))
        else $error("p_finished_quiet_r8");

    // R3: the program counter only steps up by one or restarts at zero
    p_pc_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> (pc_o == $past(pc_o) + PCW'(1) || pc_o == '0))
        else $error("p_pc_order_r3");
endmodule

// File: rtl/tac_seq.sv
module tac_seq #(
    parameter int AW      = 6,
    parameter int OPW     = 3,
    parameter int DW      = 16,
    parameter int PCW     = 4,
    parameter int BLK_LEN = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic [PCW-1:0]      imem_addr_o,
    input  logic [OPW+3*AW:0]   imem_rdata_i,
    output logic [AW-1:0]       dmem_raddr_a_o,
    output logic [AW-1:0]       dmem_raddr_b_o,
    input  logic [DW-1:0]       dmem_rdata_a_i,
    input  logic [DW-1:0]       dmem_rdata_b_i,
    output logic                dmem_we_o,
    output logic [AW-1:0]       dmem_waddr_o,
    output logic [DW-1:0]       dmem_wdata_o,
    output logic                ex_start_o,
    output logic [OPW-1:0]      ex_op_o,
    output logic [DW-1:0]       ex_a_o,
    output logic [DW-1:0]       ex_b_o,
    input  logic                ex_done_i,
    input  logic [DW-1:0]       ex_result_i,
    output logic                busy_o,
    output logic                finished_o
);
    logic [OPW+3*AW:0] instr;
    logic              blk, halt, last, clear, advance;
    logic [AW-1:0]     fa, fb, fc;

    tac_field_split #(.AW(AW), .OPW(OPW)) split_i (
        .word_i (instr),
        .blk_o  (blk),
        .op_o   (ex_op_o),
        .a_o    (fa),
        .b_o    (fb),
        .c_o    (fc),
        .halt_o (halt)
    );

    tac_addr_walk #(.AW(AW), .BLK_LEN(BLK_LEN)) walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .advance_i (advance),
        .blk_i     (blk),
        .a_i       (fa),
        .b_i       (fb),
        .c_i       (fc),
        .raddr_a_o (dmem_raddr_a_o),
        .raddr_b_o (dmem_raddr_b_o),
        .waddr_o   (dmem_waddr_o),
        .last_o    (last)
    );

    tac_ctrl_fsm #(.AW(AW), .OPW(OPW), .DW(DW), .PCW(PCW)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .imem_rdata_i (imem_rdata_i),
        .halt_i       (halt),
        .last_i       (last),
        .ex_done_i    (ex_done_i),
        .ex_result_i  (ex_result_i),
        .pc_o         (imem_addr_o),
        .instr_o      (instr),
        .clear_o      (clear),
        .advance_o    (advance),
        .ex_start_o   (ex_start_o),
        .dmem_we_o    (dmem_we_o),
        .dmem_wdata_o (dmem_wdata_o),
        .busy_o       (busy_o),
        .finished_o   (finished_o)
    );

    // operands are taken straight from the registered memory outputs
    assign ex_a_o = dmem_rdata_a_i;
    assign ex_b_o = dmem_rdata_b_i;
endmodule

// File: tb/tac_seq_tb_top.sv
module tac_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6, OPW = 3, DW = 16, PCW = 4, BLK_LEN = 18;
    localparam int IW = 1 + OPW + 3 * AW;
    localparam int DWORDS = 1 << AW;
    localparam int SLOTS = 1 << PCW;

    // R2 layout: {blk, op, A, B, C}
    function automatic logic [IW-1:0] mk(input logic blk, input int op,
                                         input int a, input int b, input int c);
        return {blk, OPW'(op), AW'(a), AW'(b), AW'(c)};
    endfunction

    // program 1 (single mode, RAW chain, halt in slot 5)
    localparam logic [IW-1:0] PROG1 [8] = '{
        mk(0, 0, 1, 2, 20),
        mk(0, 1, 20, 3, 21),
        mk(0, 2, 21, 20, 22),
        mk(0, 3, 22, 0, 1),
        mk(0, 0, 1, 1, 23),
        mk(0, 7, 0, 0, 0),
        mk(0, 0, 0, 0, 40),
        mk(0, 0, 5, 6, 41)
    };

    logic clk = 0, rst_n = 0, start_i = 0;
    logic [PCW-1:0] imem_addr;
    logic [IW-1:0]  imem_q;
    logic [AW-1:0]  ra, rb, wa;
    logic [DW-1:0]  rd_a, rd_b, wd, ex_a, ex_b;
    logic           we, ex_start, busy, finished;
    logic [OPW-1:0] ex_op;
    logic           ex_done = 0;
    logic [DW-1:0]  ex_res = 0;

    logic [IW-1:0] imem [SLOTS];
    logic [DW-1:0] dmem [DWORDS];
    logic [DW-1:0] refm [DWORDS];

    int checks = 0, fails = 0, n_starts = 0, lat = 0;
    logic done_prev = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tac_seq #(.AW(AW), .OPW(OPW), .DW(DW), .PCW(PCW), .BLK_LEN(BLK_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .imem_addr_o(imem_addr), .imem_rdata_i(imem_q),
        .dmem_raddr_a_o(ra), .dmem_raddr_b_o(rb),
        .dmem_rdata_a_i(rd_a), .dmem_rdata_b_i(rd_b),
        .dmem_we_o(we), .dmem_waddr_o(wa), .dmem_wdata_o(wd),
        .ex_start_o(ex_start), .ex_op_o(ex_op), .ex_a_o(ex_a), .ex_b_o(ex_b),
        .ex_done_i(ex_done), .ex_result_i(ex_res),
        .busy_o(busy), .finished_o(finished)
    );

    function automatic logic [DW-1:0] alu(input int op, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a ^ b;
            3: return a;
            4: return a & b;
            5: return a | b;
            default: return b;
        endcase
    endfunction

    // registered-read memories
    always @(posedge clk) begin
        imem_q <= imem[imem_addr];
        rd_a   <= dmem[ra];
        rd_b   <= dmem[rb];
        if (we) dmem[wa] <= wd;
    end

    // stub execution unit with adjustable latency
    logic pend = 0;
    int   cnt = 0;
    logic [DW-1:0] sa, sb;
    int   sop;
    always @(posedge clk) begin
        ex_done <= 1'b0;
        if (ex_start) begin
            pend <= 1'b1; cnt <= lat; sa <= ex_a; sb <= ex_b; sop <= int'(ex_op);
        end else if (pend) begin
            if (cnt == 0) begin
                ex_done <= 1'b1; ex_res <= alu(sop, sa, sb); pend <= 1'b0;
            end else cnt <= cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // port monitors: R6, R7, R8
    always @(negedge clk) begin
        if (rst_n) begin
            if (ex_start) begin
                n_starts++;
                check(!pend, "R6", "start while outstanding", 1, 0);
                check(!finished, "R8", "start while finished", 1, 0);
            end
            if (we) check(done_prev, "R7", "write without preceding done", 0, 1);
        end
        done_prev = ex_done;
    end

    // sequential reference model over the bench memories
    task automatic model(output int starts);
        starts = 0;
        for (int i = 0; i < DWORDS; i++) refm[i] = dmem[i];
        for (int pc = 0; pc < SLOTS; pc++) begin
            logic [IW-1:0] w = imem[pc];
            int op = int'(w[3*AW +: OPW]);
            int n  = w[IW-1] ? BLK_LEN : 1;
            if (op == (1 << OPW) - 1) break;
            for (int k = 0; k < n; k++) begin
                int a = (int'(w[2*AW +: AW]) + k) % DWORDS;
                int b = (int'(w[AW +: AW]) + k) % DWORDS;
                int c = (int'(w[0 +: AW]) + k) % DWORDS;
                refm[c] = alu(op, refm[a], refm[b]);
                starts++;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic run(input string req, input int poke_at);
        int exp_starts, cyc;
        model(exp_starts);
        n_starts = 0;
        pulse_start();
        cyc = 0;
        while (!finished && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (cyc == poke_at) start_i = 1;
            else start_i = 0;
        end
        start_i = 0;
        check(finished, req, "finished flag", int'(finished), 1);
        repeat (3) @(negedge clk);
        check(n_starts == exp_starts, req, "operation count", n_starts, exp_starts);
        for (int i = 0; i < DWORDS; i++)
            check(dmem[i] == refm[i], req, $sformatf("word %0d", i),
                  int'(dmem[i]), int'(refm[i]));
    endtask

    task automatic fill_data();
        for (int i = 0; i < DWORDS; i++) dmem[i] = DW'(i * 37 + 5);
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) imem[i] = '0;
        fill_data();
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !finished && !we && !ex_start, "R1", "outputs in reset",
              int'({busy, finished, we, ex_start}), 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check(!busy && !finished && !we && !ex_start, "R1", "outputs idle after reset",
              int'({busy, finished, we, ex_start}), 0);

        // table walk: R2 R3 R4 R7 R8 (halt at slot 5, later slots must not run)
        for (int i = 0; i < 8; i++) imem[i] = PROG1[i];
        lat = 3;
        run("R8", 0);

        // block mode with chained sums and address wrap: R5 R7, plus a start
        // injected mid-run that must be ignored: R10
        for (int i = 0; i < SLOTS; i++) imem[i] = '0;
        fill_data();
        imem[0] = mk(1, 0, 10, 30, 11);
        imem[1] = mk(1, 1, 60, 5, 50);
        imem[2] = mk(0, 2, 11, 28, 48);
        imem[3] = mk(0, 7, 0, 0, 0);
        lat = 0;
        run("R5", 40);

        // full program without halt, each slot depends on the previous: R3 R9 R4
        fill_data();
        for (int i = 0; i < SLOTS; i++)
            imem[i] = mk(0, (i % 3 == 2) ? 2 : 0, (i == 0) ? 63 : 31 + i, i, 32 + i);
        lat = 2;
        run("R9", 0);

        // restart from finished: R10
        lat = 1;
        begin
            int dummy;
            model(dummy);
        end
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        check(busy && !finished, "R10", "restart clears finished",
              int'({busy, finished}), 2);
        run("R10", 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule